// File: doc/BRIEF.md
# Clock-Manager Health Supervisor with Reference Failover

This block watches the status flags of an on-chip clock synthesizer (a DLL or PLL) that can be fed from either of two redundant reference clocks. It runs from a free-running supervisor clock that does not depend on the synthesizer. Every status flag passes through a two-flop synchronizer. The synthesizer counts as healthy only when its lock flag is high and none of its fault flags is raised. A raised lock flag alone is not enough.

A synthesizer of this kind does not re-acquire lock on its own once its input clock returns. When health is lost, the supervisor therefore drives a reset pulse of fixed width into the synthesizer. It then waits a programmable lock timeout and pulses again for as long as the fault stays present. On the first sampled fault it also moves the reference select to the backup clock. It moves back to the primary only after the status has stayed clean for a programmable hold-off period, and any fault during that period restarts the count. Each fault kind also sets its own sticky bit, which software clears by writing a one.

Top module: `clk_health_sup`

## Requirements
- R1: A sampled fault exists when the synchronized lock flag is low, or when the overflow, phase-error or input-lost flag is high. Any such fault starts a reset pulse when the sequencer is idle.
- R2: The output-stopped flag counts as a fault only while out_used_i is 1. While out_used_i is 0, a raised out_stop_i changes no output.
- R3: A reset pulse on mgr_rst_o lasts exactly RST_W supervisor cycles (default 3, never below 3).
- R4: After a pulse ends, mgr_rst_o stays low for lock_tmo_i+1 cycles of continuous fault and then pulses again. If the fault clears during that wait, no new pulse is issued.
- R5: ref_sel_o (0 = primary, 1 = backup) goes to 1 at the clock edge that samples a fault while it is 0.
- R6: While ref_sel_o is 1, it returns to 0 after holdoff_i consecutive fault-free sampled cycles. A holdoff_i of 0 acts as 1.
- R7: A fault sampled while the hold-off count is running restarts that count from zero, and ref_sel_o stays 1.
- R8: flt_o holds one sticky bit per fault kind: bit 0 lock lost, bit 1 overflow, bit 2 phase error, bit 3 input lost, bit 4 output stopped. A bit is set at the edge that samples its fault and stays set until it is cleared.
- R9: A one on flt_clr_i[i] for one cycle clears flt_o[i]. If the fault is sampled in the same cycle, the set wins.
- R10: After reset all outputs are 0, and the synchronizers hold the healthy pattern. A status change made between two edges reaches the outputs at the third rising edge after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running supervisor clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| lock_i | input | 1 | Synthesizer lock flag (asynchronous) |
| ovf_i | input | 1 | Synthesizer overflow flag (asynchronous) |
| phase_err_i | input | 1 | Synthesizer not-in-phase flag (asynchronous) |
| in_lost_i | input | 1 | Synthesizer input-clock-lost flag (asynchronous) |
| out_stop_i | input | 1 | Synthesized-output-stopped flag (asynchronous) |
| out_used_i | input | 1 | 1 when the synthesized output is in use (static configuration) |
| lock_tmo_i | input | TMO_W | Lock timeout after each reset pulse, in cycles |
| holdoff_i | input | HOLD_W | Fault-free cycles required before returning to the primary |
| flt_clr_i | input | 5 | Write-one-to-clear strobes for the sticky fault bits |
| mgr_rst_o | output | 1 | Reset to the clock synthesizer |
| ref_sel_o | output | 1 | Reference select, 0 primary, 1 backup |
| flt_o | output | 5 | Sticky fault bits |

## Verification
Each fault flag is raised on its own as a single-cycle glitch. This separates the flags in the sticky register and shows that one short glitch costs a single reset pulse followed by a full hold-off. A long loss of lock produces a train of pulses, which checks the pulse width and the timeout spacing against a fault that clears during a wait. A second fault placed inside a running hold-off shows that the count restarts rather than resumes. The output-stopped flag is driven with the use flag both low and high, which shows the masking. A zero hold-off, clear strobes with no fault present, and a clear that collides with an active fault cover the boundary cases.

// File: rtl/clk_sup_pkg.sv
`timescale 1ns/1ps
package clk_sup_pkg;
  localparam int unsigned FLT_N       = 5;
  localparam int unsigned FLT_LOCK    = 0;
  localparam int unsigned FLT_OVF     = 1;
  localparam int unsigned FLT_PHASE   = 2;
  localparam int unsigned FLT_INLOST  = 3;
  localparam int unsigned FLT_OUTSTOP = 4;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_PULSE = 2'd1,
    SEQ_WAIT  = 2'd2
  } seq_state_e;
endpackage

// File: rtl/clk_sup_sync.sv
`timescale 1ns/1ps
module clk_sup_sync #(
  parameter int unsigned     W       = 1,
  parameter logic [W-1:0]    RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;
  logic [1:0]   warm_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= RST_VAL;
      s2_q <= RST_VAL;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;

  // edges seen since reset, saturating at 2
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              warm_q <= 2'd0;
    else if (warm_q != 2'd2)  warm_q <= warm_q + 2'd1;
  end

  assert_sync_delay_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm_q == 2'd2) |-> (q_o == $past(d_i, 2)));
endmodule

// File: rtl/clk_sup_rstseq.sv
`timescale 1ns/1ps
module clk_sup_rstseq import clk_sup_pkg::*; #(
  parameter int unsigned RST_W = 3,
  parameter int unsigned TW    = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          fault_i,
  input  logic [TW-1:0] timeout_i,
  output logic          mgr_rst_o
);
  localparam int unsigned PW = $clog2(RST_W + 1);

  seq_state_e    st_q;
  logic [PW-1:0] pcnt_q;
  logic [TW-1:0] wcnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= SEQ_IDLE;
      pcnt_q <= '0;
      wcnt_q <= '0;
    end else begin
      unique case (st_q)
        SEQ_IDLE: if (fault_i) begin
          st_q   <= SEQ_PULSE;
          pcnt_q <= '0;
        end
        SEQ_PULSE: if (pcnt_q == PW'(RST_W - 1)) begin
          st_q   <= SEQ_WAIT;
          wcnt_q <= '0;
        end else begin
          pcnt_q <= pcnt_q + PW'(1);
        end
        SEQ_WAIT: if (!fault_i) begin
          st_q <= SEQ_IDLE;
        end else if (wcnt_q >= timeout_i) begin
          st_q   <= SEQ_PULSE;
          pcnt_q <= '0;
        end else begin
          wcnt_q <= wcnt_q + TW'(1);
        end
        default: st_q <= SEQ_IDLE;
      endcase
    end
  end

  assign mgr_rst_o = (st_q == SEQ_PULSE);

  assert_pulse_min_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mgr_rst_o) |=> mgr_rst_o ##1 mgr_rst_o);
  assert_pulse_cause_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mgr_rst_o) |-> $past(fault_i));
  assert_gap_after_pulse_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(mgr_rst_o) |=> !mgr_rst_o);
endmodule

// File: rtl/clk_sup_failover.sv
`timescale 1ns/1ps
module clk_sup_failover #(
  parameter int unsigned HW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          fault_i,
  input  logic [HW-1:0] holdoff_i,
  output logic          ref_sel_o
);
  logic          sel_q;
  logic [HW-1:0] hcnt_q;
  logic [HW:0]   need, hnext;

  // zero hold-off behaves as one clean cycle
  assign need  = (holdoff_i == '0) ? (HW+1)'(1) : {1'b0, holdoff_i};
  assign hnext = {1'b0, hcnt_q} + (HW+1)'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q  <= 1'b0;
      hcnt_q <= '0;
    end else if (!sel_q) begin
      if (fault_i) begin
        sel_q  <= 1'b1;
        hcnt_q <= '0;
      end
    end else if (fault_i) begin
      hcnt_q <= '0;
    end else if (hnext >= need) begin
      sel_q  <= 1'b0;
      hcnt_q <= '0;
    end else begin
      hcnt_q <= hnext[HW-1:0];
    end
  end

  assign ref_sel_o = sel_q;

  assert_switch_backup_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sel_q && fault_i) |=> sel_q);
  assert_hold_on_fault_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_q && fault_i) |=> sel_q);
  assert_revert_clean_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sel_q) |-> $past(!fault_i));
endmodule

// File: rtl/clk_health_sup.sv
`timescale 1ns/1ps
module clk_health_sup import clk_sup_pkg::*; #(
  parameter int unsigned RST_W  = 3,
  parameter int unsigned TMO_W  = 16,
  parameter int unsigned HOLD_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lock_i,
  input  logic              ovf_i,
  input  logic              phase_err_i,
  input  logic              in_lost_i,
  input  logic              out_stop_i,
  input  logic              out_used_i,
  input  logic [TMO_W-1:0]  lock_tmo_i,
  input  logic [HOLD_W-1:0] holdoff_i,
  input  logic [FLT_N-1:0]  flt_clr_i,
  output logic              mgr_rst_o,
  output logic              ref_sel_o,
  output logic [FLT_N-1:0]  flt_o
);
  logic [FLT_N-1:0] raw_flt, sync_flt, flt_now, flt_q;
  logic             any_fault;

  // fault polarity before the synchronizer; all-zero reset value means healthy
  always_comb begin
    raw_flt              = '0;
    raw_flt[FLT_LOCK]    = ~lock_i;
    raw_flt[FLT_OVF]     = ovf_i;
    raw_flt[FLT_PHASE]   = phase_err_i;
    raw_flt[FLT_INLOST]  = in_lost_i;
    raw_flt[FLT_OUTSTOP] = out_stop_i;
  end

  clk_sup_sync #(.W(FLT_N), .RST_VAL('0)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw_flt),
    .q_o   (sync_flt)
  );

  always_comb begin
    flt_now              = sync_flt;
    flt_now[FLT_OUTSTOP] = sync_flt[FLT_OUTSTOP] & out_used_i;
  end

  assign any_fault = |flt_now;

  clk_sup_rstseq #(.RST_W(RST_W), .TW(TMO_W)) u_rstseq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .fault_i  (any_fault),
    .timeout_i(lock_tmo_i),
    .mgr_rst_o(mgr_rst_o)
  );

  clk_sup_failover #(.HW(HOLD_W)) u_failover (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .fault_i  (any_fault),
    .holdoff_i(holdoff_i),
    .ref_sel_o(ref_sel_o)
  );

  for (genvar i = 0; i < FLT_N; i++) begin : g_sticky
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) flt_q[i] <= 1'b0;
      else         flt_q[i] <= flt_now[i] | (flt_q[i] & ~flt_clr_i[i]);
    end

    assert_sticky_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flt_q[i] && !flt_clr_i[i]) |=> flt_q[i]);
  end

  assign flt_o = flt_q;

  assert_stop_masked_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flt_q[FLT_OUTSTOP]) |-> $past(out_used_i));
  assert_fault_to_backup_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|flt_q && !$past(|flt_q)) |-> ref_sel_o);
endmodule

// File: tb/clk_health_sup_tb.sv
`timescale 1ns/1ps
module clk_health_sup_tb;
  localparam int RST_W  = 3;
  localparam int TMO_W  = 8;
  localparam int HOLD_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lock = 1'b1, ovf = 1'b0, phase = 1'b0, lost = 1'b0, stop = 1'b0, used = 1'b1;
  logic [TMO_W-1:0]  tmo  = 8'd6;
  logic [HOLD_W-1:0] hold = 8'd10;
  logic [4:0]        clr  = 5'd0;
  logic              mgr_rst, ref_sel;
  logic [4:0]        flt;

  int    vectors = 0, fails = 0;
  string cur_req = "R10";
  bit    cmp_en = 1'b0, done = 1'b0;

  always #10 clk = ~clk;

  clk_health_sup #(.RST_W(RST_W), .TMO_W(TMO_W), .HOLD_W(HOLD_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .lock_i(lock), .ovf_i(ovf), .phase_err_i(phase),
    .in_lost_i(lost), .out_stop_i(stop), .out_used_i(used), .lock_tmo_i(tmo),
    .holdoff_i(hold), .flt_clr_i(clr), .mgr_rst_o(mgr_rst), .ref_sel_o(ref_sel),
    .flt_o(flt)
  );

  // behavioural reference: two-stage delay line, then plain integer state
  logic [4:0] m_d1, m_d2, m_f, m_flt;
  int m_phase, m_pc, m_wc, m_hc, m_need;
  bit m_sel;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_d1 = '0; m_d2 = '0; m_flt = '0;
      m_phase = 0; m_pc = 0; m_wc = 0; m_hc = 0; m_sel = 1'b0;
    end else begin
      m_f = m_d2;
      if (!used) m_f[4] = 1'b0;
      m_flt = m_f | (m_flt & ~clr);
      case (m_phase)
        0: if (m_f != 0) begin m_phase = 1; m_pc = 0; end
        1: if (m_pc == RST_W - 1) begin m_phase = 2; m_wc = 0; end else m_pc++;
        default: if (m_f == 0) m_phase = 0;
                 else if (m_wc >= int'(tmo)) begin m_phase = 1; m_pc = 0; end
                 else m_wc++;
      endcase
      m_need = (hold == 0) ? 1 : int'(hold);
      if (!m_sel) begin
        if (m_f != 0) begin m_sel = 1'b1; m_hc = 0; end
      end else if (m_f != 0) m_hc = 0;
      else if (m_hc + 1 >= m_need) begin m_sel = 1'b0; m_hc = 0; end
      else m_hc++;
      m_d2 = m_d1;
      m_d1 = {stop, lost, phase, ovf, ~lock};
    end
  end

  task automatic chk(input string req, input string what, input int got, input int exp);
    vectors++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, got, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && cmp_en && !done) begin
      chk(cur_req, "mgr_rst_o", int'(mgr_rst), int'(m_phase == 1));
      chk(cur_req, "ref_sel_o", int'(ref_sel), int'(m_sel));
      chk(cur_req, "flt_o",     int'(flt),     int'(m_flt));
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic report();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog: actual running expected finished");
    report();
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    cmp_en = 1'b1;
    chk("R10", "reset mgr_rst_o", int'(mgr_rst), 0);
    chk("R10", "reset ref_sel_o", int'(ref_sel), 0);
    chk("R10", "reset flt_o", int'(flt), 0);
    step(5);

    // one-cycle overflow glitch: latency, single pulse, hold-off return
    cur_req = "R5";
    ovf = 1'b1; step(1); ovf = 1'b0; step(1);
    chk("R10", "sel before third edge", int'(ref_sel), 0);
    step(1);
    chk("R5", "sel after third edge", int'(ref_sel), 1);
    chk("R3", "pulse started", int'(mgr_rst), 1);
    step(2);
    chk("R3", "pulse still high", int'(mgr_rst), 1);
    step(1);
    chk("R3", "pulse ended", int'(mgr_rst), 0);
    cur_req = "R6"; step(20);
    chk("R6", "returned to primary", int'(ref_sel), 0);

    // fault inside a running hold-off restarts the count
    cur_req = "R7";
    lock = 1'b0; step(1); lock = 1'b1; step(6);
    ovf = 1'b1; step(1); ovf = 1'b0; step(9);
    chk("R7", "still on backup after restart", int'(ref_sel), 1);
    step(25);

    // output-stopped flag masked, then unmasked
    cur_req = "R2";
    clr = 5'h1F; step(1); clr = 5'h00;
    used = 1'b0; stop = 1'b1; step(10);
    chk("R2", "masked stop bit", int'(flt[4]), 0);
    chk("R2", "masked stop sel", int'(ref_sel), 0);
    used = 1'b1; step(4);
    chk("R2", "unmasked stop bit", int'(flt[4]), 1);
    stop = 1'b0; step(30);

    // long lock loss: pulse train spaced by the timeout
    cur_req = "R4";
    lock = 1'b0; step(40); lock = 1'b1; step(30);
    // fault that clears during the wait
    lock = 1'b0; step(4); lock = 1'b1; step(30);

    // each remaining flag alone
    cur_req = "R1";
    clr = 5'h1F; step(1); clr = 5'h00;
    phase = 1'b1; step(1); phase = 1'b0; step(4);
    chk("R8", "phase sets bit 2 only", int'(flt), 5'b00100);
    step(20);
    lost = 1'b1; step(1); lost = 1'b0; step(4);
    chk("R8", "input lost sets bit 3", int'(flt[3]), 1);
    step(20);

    // write-one-to-clear, and set winning over clear
    cur_req = "R9";
    clr = 5'h1F; step(1); clr = 5'h00;
    chk("R9", "cleared all", int'(flt), 0);
    ovf = 1'b1; step(6);
    clr = 5'b00010; step(1); clr = 5'h00;
    chk("R9", "set wins over clear", int'(flt[1]), 1);
    ovf = 1'b0; step(25);

    // zero hold-off acts as one cycle
    cur_req = "R6";
    hold = 8'd0;
    ovf = 1'b1; step(1); ovf = 1'b0; step(6);
    chk("R6", "zero hold-off returned", int'(ref_sel), 0);
    step(10);

    report();
  end
endmodule